// File: doc/BRIEF.md
# Switch Memory Auto-Initialisation Sequencer

This block fills the connection memories of a time-slot interchange switch in hardware, so that software does not have to write every location one by one. A byte-wide register port holds three registers: a control/identification register, a command register and a source register. Software writes a fill mode into the control register. The sequencer then walks every address of the chosen memory, one address per clock, and shows a busy flag while it runs.

There are three fills. The first copies a register pattern into every command-memory word. The second splits the source pattern across the two 16-channel auxiliary memories: the monitor memory and the command/indicate memory. The third builds an identity map, in which input slot t of input multiplex m goes to output slot t of output multiplex m. When a fill completes, the mode field returns to normal by itself. A soft-reset bit returns every register to its reset value and cancels a fill that is running. The three memories are internal synchronous RAMs. Software can also write and read them directly through a separate memory port.

Top module: `swmem_init_seq`

## Requirements
- R1: After reset, busy is 0 and registers 0, 1 and 2 all read 0x00.
- R2: Register 0 is laid out as follows. Bit 7 is the bank select and bits 5:4 are the mode: 00 run, 01 auto-fill, 10 test, 11 identity. Bit 6 is the soft-reset strobe and always reads 0. Bits 3:0 always read 0.
- R3: Bank select 1 hides registers 1 and 2: they read 0 and writes to them are ignored. Addresses 3 to 15 always read 0.
- R4: Mode 01 with command-register bit 7 = 1 writes {command[5:0], source[7:0]} into every command-memory address. Busy is high for exactly NMUX*32 cycles, starting the cycle after the mode write, and the auxiliary memories are unchanged.
- R5: Mode 01 with command-register bit 7 = 0 writes source[7:0] into all 16 monitor entries and source[5:0] into all 16 command/indicate entries. Busy is high for exactly 16 cycles, and the command memory is unchanged.
- R6: Mode 11 writes {m, t} zero-extended into the address m*32+t of the command memory. This takes NMUX*32 busy cycles.
- R7: In the cycle where busy falls at the end of a fill, the mode field reads 00.
- R8: Mode 10 is stored and reads back. It raises no busy and changes no memory.
- R9: While busy is high, memory-port writes are ignored and writes to the mode field are ignored.
- R10: Writing register 0 with bit 6 = 1 returns all registers to 0, ignores the other written bits, and stops a running fill. Busy is low from the next cycle.
- R11: While idle, the memory port writes the selected memory (mem_sel 0 command, 1 monitor, 2 command/indicate), and the auxiliary memories use the low 4 address bits. Read data appears one cycle after the address and select are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_wr | input | 1 | Memory-port write strobe |
| mem_sel | input | 2 | Memory select: 0 command, 1 monitor, 2 command/indicate |
| mem_addr | input | CAW (8) | Memory address |
| mem_wdata | input | 14 | Memory write data |
| mem_rdata | output | 14 | Memory read data, one cycle latency |
| busy | output | 1 | Fill in progress |

## Verification
A wrong fill counter or a wrong terminal address changes the length of the busy pulse. The bench catches this within one cycle of the expected falling edge. A bad word mux or a write enable steered to the wrong memory leaves wrong words behind. Full read-back sweeps find these, including words that a fill must leave alone. A mode field that is not cleared on completion, or that can be overwritten while busy, shows on the next read of register 0.

// File: rtl/swinit_pkg.sv
package swinit_pkg;

    localparam int SLOTS_PER_MUX = 32;
    localparam int AUX_CHANNELS  = 16;
    localparam int CMD_WORD_W    = 14;
    localparam int MON_WORD_W    = 8;
    localparam int CI_WORD_W     = 6;

    localparam logic [3:0] ADDR_CTRL = 4'd0;
    localparam logic [3:0] ADDR_CMD  = 4'd1;
    localparam logic [3:0] ADDR_SRC  = 4'd2;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_AUTO  = 2'b01,
        MODE_TEST  = 2'b10,
        MODE_IDENT = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        FILL_NONE    = 2'd0,
        FILL_PATTERN = 2'd1,
        FILL_AUX     = 2'd2,
        FILL_IDENT   = 2'd3
    } fill_e;

    typedef enum logic [1:0] {
        MSEL_CMD  = 2'd0,
        MSEL_MON  = 2'd1,
        MSEL_CI   = 2'd2,
        MSEL_NONE = 2'd3
    } msel_e;

    typedef struct packed {
        fill_e      kind;
        logic [5:0] ctl;
        logic [7:0] pat;
    } fill_req_t;

    function automatic fill_e fill_kind(input logic [1:0] mode, input logic cm);
        fill_e k;
        case (mode)
            MODE_AUTO:  k = cm ? FILL_PATTERN : FILL_AUX;
            MODE_IDENT: k = FILL_IDENT;
            default:    k = FILL_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [CMD_WORD_W-1:0] pattern_word(input logic [5:0] ctl,
                                                           input logic [7:0] pat);
        return {ctl, pat};
    endfunction

endpackage

// File: rtl/swinit_ram.sv
module swinit_ram #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end

endmodule

// File: rtl/swinit_regs.sv
module swinit_regs
    import swinit_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    input  logic      busy,
    input  logic      fill_done,
    output logic [7:0] rdata,
    output mode_e     mode_o,
    output logic      start_o,
    output logic      soft_rst_o,
    output fill_req_t req_o
);

    logic       bank_q;
    mode_e      mode_q;
    logic [7:0] cmd_q;
    logic [7:0] src_q;

    logic ctrl_wr;
    logic mode_wr_ok;
    logic main_wr_ok;

    assign ctrl_wr    = wr && (addr == ADDR_CTRL);
    assign soft_rst_o = ctrl_wr && wdata[6];
    assign mode_wr_ok = ctrl_wr && !wdata[6] && !busy;
    assign main_wr_ok = wr && !bank_q;
    assign start_o    = mode_wr_ok &&
                        (wdata[5:4] == MODE_AUTO || wdata[5:4] == MODE_IDENT);

    always_ff @(posedge clk) begin
        if (rst || soft_rst_o) begin
            bank_q <= 1'b0;
            mode_q <= MODE_RUN;
            cmd_q  <= '0;
            src_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                bank_q <= wdata[7];
            end
            if (mode_wr_ok) begin
                mode_q <= mode_e'(wdata[5:4]);
            end else if (fill_done) begin
                mode_q <= MODE_RUN;
            end
            if (main_wr_ok && addr == ADDR_CMD) begin
                cmd_q <= wdata;
            end
            if (main_wr_ok && addr == ADDR_SRC) begin
                src_q <= wdata;
            end
        end
    end

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {bank_q, 1'b0, mode_q, 4'b0000};
            ADDR_CMD:  rdata = bank_q ? 8'h00 : cmd_q;
            ADDR_SRC:  rdata = bank_q ? 8'h00 : src_q;
            default:   rdata = 8'h00;
        endcase
    end

    assign mode_o      = mode_q;
    assign req_o.kind  = fill_kind(wdata[5:4], cmd_q[7]);
    assign req_o.ctl   = cmd_q[5:0];
    assign req_o.pat   = src_q;

endmodule

// File: rtl/swinit_seq.sv
module swinit_seq
    import swinit_pkg::*;
#(
    parameter int CMD_DEPTH = 256,
    parameter int AUX_DEPTH = 16,
    localparam int CAW = $clog2(CMD_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  abort,
    input  logic                  start,
    input  fill_req_t             req,
    output logic                  busy,
    output logic                  done,
    output logic                  cmd_we,
    output logic                  aux_we,
    output logic [CAW-1:0]        addr,
    output logic [CMD_WORD_W-1:0] cmd_wdata,
    output logic [MON_WORD_W-1:0] mon_wdata,
    output logic [CI_WORD_W-1:0]  ci_wdata
);

    localparam logic [CAW-1:0] CMD_LAST = CAW'(CMD_DEPTH - 1);
    localparam logic [CAW-1:0] AUX_LAST = CAW'(AUX_DEPTH - 1);

    fill_e          kind_q;
    logic [CAW-1:0] cnt_q;
    logic [5:0]     ctl_q;
    logic [7:0]     pat_q;
    logic [CAW-1:0] last_addr;

    assign last_addr = (kind_q == FILL_AUX) ? AUX_LAST : CMD_LAST;
    assign busy      = (kind_q != FILL_NONE);
    assign done      = busy && (cnt_q == last_addr);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            kind_q <= FILL_NONE;
            cnt_q  <= '0;
            ctl_q  <= '0;
            pat_q  <= '0;
        end else if (start && !busy) begin
            kind_q <= req.kind;
            cnt_q  <= '0;
            ctl_q  <= req.ctl;
            pat_q  <= req.pat;
        end else if (busy) begin
            if (done) begin
                kind_q <= FILL_NONE;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + CAW'(1);
            end
        end
    end

    assign cmd_we    = (kind_q == FILL_PATTERN) || (kind_q == FILL_IDENT);
    assign aux_we    = (kind_q == FILL_AUX);
    assign addr      = cnt_q;
    assign cmd_wdata = (kind_q == FILL_IDENT) ? CMD_WORD_W'(cnt_q)
                                              : pattern_word(ctl_q, pat_q);
    assign mon_wdata = pat_q;
    assign ci_wdata  = pat_q[5:0];

endmodule

// File: rtl/swmem_init_seq.sv
module swmem_init_seq
    import swinit_pkg::*;
#(
    parameter int NMUX = 8,
    localparam int CAW = $clog2(NMUX * SLOTS_PER_MUX)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [3:0]            reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  mem_wr,
    input  logic [1:0]            mem_sel,
    input  logic [CAW-1:0]        mem_addr,
    input  logic [CMD_WORD_W-1:0] mem_wdata,
    output logic [CMD_WORD_W-1:0] mem_rdata,
    output logic                  busy
);

    localparam int CMD_DEPTH = NMUX * SLOTS_PER_MUX;
    localparam int XAW       = $clog2(AUX_CHANNELS);

    mode_e      mode;
    logic       start;
    logic       soft_rst;
    fill_req_t  req;
    logic       seq_done;
    logic       seq_cmd_we;
    logic       seq_aux_we;
    logic [CAW-1:0] seq_addr;
    logic [CMD_WORD_W-1:0] seq_cmd_wdata;
    logic [MON_WORD_W-1:0] seq_mon_wdata;
    logic [CI_WORD_W-1:0]  seq_ci_wdata;

    swinit_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .busy       (busy),
        .fill_done  (seq_done),
        .rdata      (reg_rdata),
        .mode_o     (mode),
        .start_o    (start),
        .soft_rst_o (soft_rst),
        .req_o      (req)
    );

    swinit_seq #(
        .CMD_DEPTH (CMD_DEPTH),
        .AUX_DEPTH (AUX_CHANNELS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .abort     (soft_rst),
        .start     (start),
        .req       (req),
        .busy      (busy),
        .done      (seq_done),
        .cmd_we    (seq_cmd_we),
        .aux_we    (seq_aux_we),
        .addr      (seq_addr),
        .cmd_wdata (seq_cmd_wdata),
        .mon_wdata (seq_mon_wdata),
        .ci_wdata  (seq_ci_wdata)
    );

    // Write-port steering: the sequencer owns the memories while busy.
    logic                  cmd_we, mon_we, ci_we;
    logic [CAW-1:0]        cmd_waddr;
    logic [XAW-1:0]        aux_waddr;
    logic [CMD_WORD_W-1:0] cmd_wdata;
    logic [MON_WORD_W-1:0] mon_wdata;
    logic [CI_WORD_W-1:0]  ci_wdata;

    always_comb begin
        if (busy) begin
            cmd_we    = seq_cmd_we;
            mon_we    = seq_aux_we;
            ci_we     = seq_aux_we;
            cmd_waddr = seq_addr;
            aux_waddr = seq_addr[XAW-1:0];
            cmd_wdata = seq_cmd_wdata;
            mon_wdata = seq_mon_wdata;
            ci_wdata  = seq_ci_wdata;
        end else begin
            cmd_we    = mem_wr && (mem_sel == MSEL_CMD);
            mon_we    = mem_wr && (mem_sel == MSEL_MON);
            ci_we     = mem_wr && (mem_sel == MSEL_CI);
            cmd_waddr = mem_addr;
            aux_waddr = mem_addr[XAW-1:0];
            cmd_wdata = mem_wdata;
            mon_wdata = mem_wdata[MON_WORD_W-1:0];
            ci_wdata  = mem_wdata[CI_WORD_W-1:0];
        end
    end

    logic [CMD_WORD_W-1:0] cmd_rdata;
    logic [MON_WORD_W-1:0] mon_rdata;
    logic [CI_WORD_W-1:0]  ci_rdata;

    swinit_ram #(.WIDTH(CMD_WORD_W), .DEPTH(CMD_DEPTH)) u_cmd_ram (
        .clk   (clk),
        .we    (cmd_we),
        .waddr (cmd_waddr),
        .wdata (cmd_wdata),
        .raddr (mem_addr),
        .rdata (cmd_rdata)
    );

    swinit_ram #(.WIDTH(MON_WORD_W), .DEPTH(AUX_CHANNELS)) u_mon_ram (
        .clk   (clk),
        .we    (mon_we),
        .waddr (aux_waddr),
        .wdata (mon_wdata),
        .raddr (mem_addr[XAW-1:0]),
        .rdata (mon_rdata)
    );

    swinit_ram #(.WIDTH(CI_WORD_W), .DEPTH(AUX_CHANNELS)) u_ci_ram (
        .clk   (clk),
        .we    (ci_we),
        .waddr (aux_waddr),
        .wdata (ci_wdata),
        .raddr (mem_addr[XAW-1:0]),
        .rdata (ci_rdata)
    );

    msel_e rsel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsel_q <= MSEL_NONE;
        end else begin
            rsel_q <= msel_e'(mem_sel);
        end
    end

    always_comb begin
        case (rsel_q)
            MSEL_CMD: mem_rdata = cmd_rdata;
            MSEL_MON: mem_rdata = CMD_WORD_W'(mon_rdata);
            MSEL_CI:  mem_rdata = CMD_WORD_W'(ci_rdata);
            default:  mem_rdata = '0;
        endcase
    end

endmodule

// File: rtl/swmem_init_chk.sv
module swmem_init_chk
    import swinit_pkg::*;
#(
    parameter int CAW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input mode_e          mode,
    input logic           seq_cmd_we,
    input logic           seq_aux_we,
    input logic [CAW-1:0] seq_addr,
    input logic [3:0]     reg_addr,
    input logic [7:0]     reg_rdata
);

    AST_ID_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 4'd0) |-> (reg_rdata[3:0] == 4'd0 && reg_rdata[6] == 1'b0)); // R2

    AST_FILL_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        !(seq_cmd_we && seq_aux_we)); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (seq_addr == $past(seq_addr) + CAW'(1))); // R4

    AST_END_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (mode == MODE_RUN)); // R7

    AST_TEST_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TEST) |-> !busy); // R8

    AST_BUSY_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |-> (mode == MODE_AUTO || mode == MODE_IDENT)); // R9

endmodule

bind swmem_init_seq swmem_init_chk #(.CAW(CAW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .mode       (mode),
    .seq_cmd_we (seq_cmd_we),
    .seq_aux_we (seq_aux_we),
    .seq_addr   (seq_addr),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata)
);

// File: tb/swmem_init_seq_bench.sv
`timescale 1ns/1ps
module swmem_init_seq_bench;

    localparam int NMUX = 8;
    localparam int CAW  = $clog2(NMUX * 32);
    localparam int NCMD = NMUX * 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mem_wr = 1'b0;
    logic [1:0]  mem_sel = 2'd3;
    logic [CAW-1:0] mem_addr = '0;
    logic [13:0] mem_wdata = '0;
    logic [13:0] mem_rdata;
    logic        busy;

    swmem_init_seq #(.NMUX(NMUX)) u_swmem_init_seq (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_wr    (mem_wr),
        .mem_sel   (mem_sel),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          issue;
        logic [13:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data one cycle after each issued read.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].issue + 1 == cyc) begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk(it.tag, {18'd0, mem_rdata}, {18'd0, it.exp});
        end
    end

    task automatic rd_expect(input logic [1:0] sel, input int a, input logic [13:0] exp,
                             input string tag);
        sb_item_t it;
        @(negedge clk);
        mem_sel  = sel;
        mem_addr = CAW'(a);
        it.issue = cyc;
        it.exp   = exp;
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    task automatic sb_drain();
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_expect(input logic [3:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    task automatic mem_write(input logic [1:0] sel, input int a, input logic [13:0] d);
        @(negedge clk);
        mem_wr = 1'b1; mem_sel = sel; mem_addr = CAW'(a); mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    // Called right after the mode write returns; busy must fall exactly n edges later.
    task automatic wait_fill(input int start_cyc, input int n, input string tag);
        while (cyc < start_cyc + n - 1) @(negedge clk);
        chk({tag, " busy held"}, {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk({tag, " busy fell"}, {31'd0, busy}, 32'd0);
        reg_expect(4'd0, 8'h00, "R7 mode cleared at end");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        reg_expect(4'd0, 8'h00, "R1 reg0");
        reg_expect(4'd1, 8'h00, "R1 reg1");
        reg_expect(4'd2, 8'h00, "R1 reg2");

        // R11 direct memory access while idle
        mem_write(2'd0, 7, 14'h1234);
        mem_write(2'd1, 3, 14'h00A5);
        mem_write(2'd2, 3, 14'h3FFF);
        rd_expect(2'd0, 7, 14'h1234, "R11 cmd rd");
        rd_expect(2'd1, 3, 14'h00A5, "R11 mon rd");
        rd_expect(2'd2, 3, 14'h003F, "R11 ci rd");
        sb_drain();

        // R2 / R3 register layout and bank select
        reg_write(4'd1, 8'h85);
        reg_write(4'd2, 8'h3C);
        reg_expect(4'd1, 8'h85, "R3 reg1 bank0");
        reg_expect(4'd2, 8'h3C, "R3 reg2 bank0");
        reg_write(4'd0, 8'h8F);
        reg_expect(4'd0, 8'h80, "R2 reg0 low nibble zero");
        reg_expect(4'd1, 8'h00, "R3 reg1 hidden");
        reg_write(4'd1, 8'h11);
        reg_write(4'd0, 8'h00);
        reg_expect(4'd1, 8'h85, "R3 reg1 write ignored in bank1");
        reg_expect(4'd5, 8'h00, "R3 unused address");

        // R8 test mode: stored, no fill
        reg_write(4'd0, 8'h20);
        chk("R8 no busy", {31'd0, busy}, 32'd0);
        reg_expect(4'd0, 8'h20, "R8 mode readback");
        repeat (3) @(negedge clk);
        chk("R8 still idle", {31'd0, busy}, 32'd0);
        rd_expect(2'd0, 7, 14'h1234, "R8 cmd unchanged");
        sb_drain();
        reg_write(4'd0, 8'h00);

        // R4 pattern fill with R9 interference
        reg_write(4'd0, 8'h10);
        s = cyc;
        chk("R4 busy rose", {31'd0, busy}, 32'd1);
        mem_write(2'd0, 7, 14'h0001);
        reg_write(4'd0, 8'h30);
        reg_expect(4'd0, 8'h10, "R9 mode write ignored while busy");
        wait_fill(s, NCMD, "R4");
        for (int a = 0; a < NCMD; a++) rd_expect(2'd0, a, 14'h053C, "R4/R9 cmd word");
        rd_expect(2'd1, 3, 14'h00A5, "R4 mon untouched");
        sb_drain();

        // R5 auxiliary fill
        reg_write(4'd1, 8'h05);
        reg_write(4'd2, 8'hC9);
        reg_write(4'd0, 8'h10);
        s = cyc;
        chk("R5 busy rose", {31'd0, busy}, 32'd1);
        wait_fill(s, 16, "R5");
        for (int a = 0; a < 16; a++) begin
            rd_expect(2'd1, a, 14'h00C9, "R5 mon word");
            rd_expect(2'd2, a, 14'h0009, "R5 ci word");
        end
        rd_expect(2'd0, 100, 14'h053C, "R5 cmd untouched");
        sb_drain();

        // R6 identity map
        reg_write(4'd0, 8'h30);
        s = cyc;
        chk("R6 busy rose", {31'd0, busy}, 32'd1);
        wait_fill(s, NCMD, "R6");
        for (int a = 0; a < NCMD; a++) rd_expect(2'd0, a, 14'(a), "R6 identity word");
        sb_drain();

        // R10 soft reset aborts a pattern fill
        reg_write(4'd1, 8'h85);
        reg_write(4'd2, 8'h3C);
        reg_write(4'd0, 8'h10);
        repeat (10) @(negedge clk);
        chk("R10 busy before abort", {31'd0, busy}, 32'd1);
        reg_write(4'd0, 8'hC0);
        chk("R10 busy after abort", {31'd0, busy}, 32'd0);
        reg_expect(4'd0, 8'h00, "R10 reg0 cleared");
        reg_expect(4'd1, 8'h00, "R10 reg1 cleared");
        reg_expect(4'd2, 8'h00, "R10 reg2 cleared");
        rd_expect(2'd0, 0, 14'h053C, "R10 early address filled");
        rd_expect(2'd0, NCMD - 1, 14'(NCMD - 1), "R10 late address untouched");
        sb_drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule